// File: doc/BRIEF.md
# Memory-Mapped Peripheral Bus Decoder

This block sits on the load/store port of a 32-bit processor. Every access address is sorted into one of two spaces. Addresses below 0xA0000000 go to data memory. The enables, address, size and store data are passed through, and the memory's read data is returned unchanged. Addresses from 0xA0000000 up are an I/O window. The block serves that window itself.

The I/O window holds five devices:
- a read-only microsecond run-time counter, driven by a clock prescaler;
- a 16-bit light register that can be read and written;
- two read-only 16-bit input ports, one for switches and one for push buttons, each re-timed through two flops;
- a write-only serial port, where a word store emits the stored word's low byte with a one-cycle strobe.

Device reads are trimmed to the access size and zero-extended. Reads of any unused address in the window return zero.

Top module: `mmio_bus_decoder`

## Requirements
- R1: An access with address below 0xA0000000 is a memory access. mem_rd_en and mem_wr_en follow cpu_rd_en and cpu_wr_en, and a read returns mem_rdata unchanged.
- R2: An access with address at or above 0xA0000000 never raises mem_rd_en or mem_wr_en.
- R3: The counter read at 0xA0000048 is zero after reset. It then rises by one every CLK_MHZ clock cycles and wraps to zero after 2^TIME_W - 1.
- R4: The light register at 0xA0000400 resets to zero. A store of size code 1 (half) or 2/3 (word) loads cpu_wdata[15:0]. A byte store (size code 0) leaves it unchanged. It is visible on led_out and by reads.
- R5: A read at 0xA0000500 returns switch_in as it was two rising edges earlier (two-flop re-timing, reset value zero).
- R6: A read at 0xA0000600 returns button_in as it was two rising edges earlier (same re-timing).
- R7: A store of size code 2 or 3 to 0xA00003F8 raises ser_valid for the one cycle after the storing edge, with ser_byte equal to cpu_wdata[7:0]. Stores of size code 0 or 1 there emit nothing.
- R8: Stores to the counter, switch and button addresses change neither the light register nor the counter's progress.
- R9: A read of an address in the I/O window with no readable device, including the serial port, returns zero.
- R10: I/O read data is sized by cpu_size. Code 0 keeps bits 7:0, code 1 keeps bits 15:0, and codes 2 and 3 keep all 32 bits. Bits that are not kept read as zero.
- R11: cpu_rdata is zero whenever cpu_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Access address |
| cpu_rd_en | input | 1 | Load request |
| cpu_wr_en | input | 1 | Store request |
| cpu_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| mem_addr | output | 32 | Address to data memory |
| mem_size | output | 2 | Access size to data memory |
| mem_wdata | output | 32 | Store data to data memory |
| mem_rd_en | output | 1 | Memory load enable |
| mem_wr_en | output | 1 | Memory store enable |
| mem_rdata | input | 32 | Memory load data |
| switch_in | input | SW_W | Raw switch levels |
| button_in | input | BTN_W | Raw button levels |
| led_out | output | LED_W | Light register contents |
| ser_valid | output | 1 | Serial byte strobe |
| ser_byte | output | 8 | Serial byte |

## Verification
The bench probes both edges of the window. It checks that 0x9FFFFFFC still reaches memory, and that 0xA0000000 and 0xFFFFFFFC are treated as I/O and read zero. A decoder with an off-by-one bound would send one of these to the wrong side.

Input ports are changed and then read on every cycle. A design with one flop or three would show the new value a cycle early or a cycle late.

Serial stores are issued back to back and with short sizes. A stretched strobe, or one fired by a halfword store, would show up at once.

A second instance uses a small counter and a divide-by-three prescaler, so the wrap to zero and the exact tick spacing are both observed.

// File: rtl/mmio_pkg.sv
// Shared constants and types for the peripheral bus decoder.
// Assumes a 32-bit byte address and a two-bit access size code.
package mmio_pkg;

    localparam logic [31:0] IO_BASE     = 32'hA000_0000;
    localparam logic [31:0] ADDR_TIME   = 32'hA000_0048;
    localparam logic [31:0] ADDR_SERIAL = 32'hA000_03F8;
    localparam logic [31:0] ADDR_LED    = 32'hA000_0400;
    localparam logic [31:0] ADDR_SWITCH = 32'hA000_0500;
    localparam logic [31:0] ADDR_BUTTON = 32'hA000_0600;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_MEM,
        RG_TIME,
        RG_LED,
        RG_SWITCH,
        RG_BUTTON,
        RG_SERIAL,
        RG_VOID
    } region_e;

    // Bit mask kept by a read of the given size code.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        logic [31:0] m;
        case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    // True when the size code denotes a full word.
    function automatic logic is_word(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
// Address decoder: sorts an access address into memory, one of the
// device slots, or an unused hole of the I/O window.
// Assumes exact full-address matches for device slots.
module mmio_addr_decode
    import mmio_pkg::*;
(
    input  logic [31:0] addr,
    output region_e     region
);

    // Classify the address; memory below the window base.
    always_comb begin
        if (addr < IO_BASE)              region = RG_MEM;
        else if (addr == ADDR_TIME)      region = RG_TIME;
        else if (addr == ADDR_LED)       region = RG_LED;
        else if (addr == ADDR_SWITCH)    region = RG_SWITCH;
        else if (addr == ADDR_BUTTON)    region = RG_BUTTON;
        else if (addr == ADDR_SERIAL)    region = RG_SERIAL;
        else                             region = RG_VOID;
    end

endmodule

// File: rtl/mmio_usec_timer.sv
// Free-running microsecond counter. A prescaler divides the clock by
// CLK_MHZ so the counter advances once per microsecond.
// Assumes CLK_MHZ >= 1; the counter wraps at 2^TIME_W.
module mmio_usec_timer #(
    parameter int CLK_MHZ = 100,
    parameter int TIME_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [TIME_W-1:0] usec
);

    localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

    logic tick;

    generate
        if (CLK_MHZ <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_prescale
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);
            logic [PRE_W-1:0] pre_q;

            // Prescaler: count 0..CLK_MHZ-1 and roll over.
            always_ff @(posedge clk) begin
                if (!rst_n)               pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                      pre_q <= pre_q + 1'b1;
            end

            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    // Microsecond count: step on each prescaler roll-over.
    always_ff @(posedge clk) begin
        if (!rst_n)    usec <= '0;
        else if (tick) usec <= usec + 1'b1;
    end

endmodule

// File: rtl/mmio_in_sync.sv
// Two-flop re-timing stage for a slow external input bus.
// Assumes the input changes far slower than the clock; no debouncing.
module mmio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    logic [W-1:0] stage1;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            synced <= '0;
        end else begin
            stage1 <= raw;
            synced <= stage1;
        end
    end

endmodule

// File: rtl/mmio_out_regs.sv
// Output registers: the light register and the serial byte strobe.
// Assumes write enables are already qualified by address and size.
module mmio_out_regs #(
    parameter int LED_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             led_we,
    input  logic [LED_W-1:0] led_wdata,
    input  logic             ser_we,
    input  logic [7:0]       ser_wdata,
    output logic [LED_W-1:0] led_q,
    output logic             ser_valid,
    output logic [7:0]       ser_byte
);

    // Light register: load on a qualified store.
    always_ff @(posedge clk) begin
        if (!rst_n)      led_q <= '0;
        else if (led_we) led_q <= led_wdata;
    end

    // Serial strobe: one cycle per qualified store, byte held after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_valid <= 1'b0;
            ser_byte  <= '0;
        end else begin
            ser_valid <= ser_we;
            if (ser_we) ser_byte <= ser_wdata;
        end
    end

endmodule

// File: rtl/mmio_bus_decoder.sv
// Peripheral bus decoder between a processor load/store port, data
// memory and a fixed set of memory-mapped devices.
// Assumes single-cycle accesses; loads are answered combinationally
// from memory read data or from device state.
module mmio_bus_decoder
    import mmio_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int TIME_W  = 32,
    parameter int LED_W   = 16,
    parameter int SW_W    = 16,
    parameter int BTN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cpu_addr,
    input  logic             cpu_rd_en,
    input  logic             cpu_wr_en,
    input  logic [1:0]       cpu_size,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    output logic [31:0]      mem_addr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    input  logic [31:0]      mem_rdata,
    input  logic [SW_W-1:0]  switch_in,
    input  logic [BTN_W-1:0] button_in,
    output logic [LED_W-1:0] led_out,
    output logic             ser_valid,
    output logic [7:0]       ser_byte
);

    region_e           region;
    logic [TIME_W-1:0] usec_now;
    logic [SW_W-1:0]   sw_sync;
    logic [BTN_W-1:0]  btn_sync;
    logic              led_we;
    logic              ser_we;
    logic [31:0]       dev_word;

    mmio_addr_decode u_decode (
        .addr   (cpu_addr),
        .region (region)
    );

    mmio_usec_timer #(
        .CLK_MHZ (CLK_MHZ),
        .TIME_W  (TIME_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .usec  (usec_now)
    );

    mmio_in_sync #(.W(SW_W)) u_sw_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (switch_in),
        .synced (sw_sync)
    );

    mmio_in_sync #(.W(BTN_W)) u_btn_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (button_in),
        .synced (btn_sync)
    );

    // Qualify device stores by slot and size.
    assign led_we = cpu_wr_en && (region == RG_LED) && (cpu_size != SZ_BYTE);
    assign ser_we = cpu_wr_en && (region == RG_SERIAL) && is_word(cpu_size);

    mmio_out_regs #(.LED_W(LED_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_we    (led_we),
        .led_wdata (cpu_wdata[LED_W-1:0]),
        .ser_we    (ser_we),
        .ser_wdata (cpu_wdata[7:0]),
        .led_q     (led_out),
        .ser_valid (ser_valid),
        .ser_byte  (ser_byte)
    );

    // Memory side: pass the access through only below the window.
    assign mem_addr  = cpu_addr;
    assign mem_size  = cpu_size;
    assign mem_wdata = cpu_wdata;
    assign mem_rd_en = cpu_rd_en && (region == RG_MEM);
    assign mem_wr_en = cpu_wr_en && (region == RG_MEM);

    // Device read word, zero-extended; holes read zero.
    always_comb begin
        case (region)
            RG_TIME:   dev_word = 32'(usec_now);
            RG_LED:    dev_word = 32'(led_out);
            RG_SWITCH: dev_word = 32'(sw_sync);
            RG_BUTTON: dev_word = 32'(btn_sync);
            default:   dev_word = '0;
        endcase
    end

    // Load data: memory as is, devices trimmed to the access size.
    always_comb begin
        if (!cpu_rd_en)            cpu_rdata = '0;
        else if (region == RG_MEM) cpu_rdata = mem_rdata;
        else                       cpu_rdata = dev_word & size_mask(cpu_size);
    end

endmodule

// File: rtl/mmio_bus_decoder_chk.sv
// Property checker for the peripheral bus decoder, bound to the top.
module mmio_bus_decoder_chk
    import mmio_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int LED_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cpu_addr,
    input logic              cpu_rd_en,
    input logic              cpu_wr_en,
    input logic [1:0]        cpu_size,
    input logic [31:0]       cpu_rdata,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [LED_W-1:0]  led_out,
    input logic              ser_valid,
    input logic [TIME_W-1:0] usec_now
);

    // R2: no memory enable for window addresses.
    assert_mem_quiet_io_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= IO_BASE) |-> (!mem_rd_en && !mem_wr_en));

    // R3: the counter only ever steps by one.
    assert_time_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (usec_now != $past(usec_now)) |-> (usec_now == TIME_W'($past(usec_now) + 1'b1)));

    // R4: the light register moves only after a half or word store to it.
    assert_led_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr_en && (cpu_addr == ADDR_LED) && (cpu_size != 2'd0)) |=> $stable(led_out));

    // R7: every strobe follows a word store to the serial slot.
    assert_ser_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(cpu_wr_en && (cpu_addr == ADDR_SERIAL) && cpu_size[1]));

    // R9: holes in the window read zero.
    assert_hole_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_en && (cpu_addr >= IO_BASE) && (cpu_addr != ADDR_TIME) &&
         (cpu_addr != ADDR_LED) && (cpu_addr != ADDR_SWITCH) &&
         (cpu_addr != ADDR_BUTTON)) |-> (cpu_rdata == 32'd0));

    // R11: idle load port reads zero.
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_en |-> (cpu_rdata == 32'd0));

endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk #(
    .TIME_W (TIME_W),
    .LED_W  (LED_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd_en (cpu_rd_en),
    .cpu_wr_en (cpu_wr_en),
    .cpu_size  (cpu_size),
    .cpu_rdata (cpu_rdata),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .led_out   (led_out),
    .ser_valid (ser_valid),
    .usec_now  (usec_now)
);

// File: tb/tb_mmio_bus_decoder.sv
module tb_mmio_bus_decoder;

    localparam logic [31:0] A_TIME = 32'hA000_0048;
    localparam logic [31:0] A_SER  = 32'hA000_03F8;
    localparam logic [31:0] A_LED  = 32'hA000_0400;
    localparam logic [31:0] A_SW   = 32'hA000_0500;
    localparam logic [31:0] A_BTN  = 32'hA000_0600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_rd_en = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [31:0] mem_rdata = 32'hDEAD_0001;
    logic [15:0] switch_in = '0;
    logic [15:0] button_in = '0;
    logic [15:0] led_out;
    logic        ser_valid;
    logic [7:0]  ser_byte;

    logic [31:0] w_rdata;
    logic [31:0] w_mem_addr, w_mem_wdata;
    logic [1:0]  w_mem_size;
    logic        w_mem_rd, w_mem_wr;
    logic [15:0] w_led;
    logic        w_sv;
    logic [7:0]  w_sb;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mmio_bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd_en(cpu_rd_en),
        .cpu_wr_en(cpu_wr_en), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_rdata(mem_rdata), .switch_in(switch_in), .button_in(button_in),
        .led_out(led_out), .ser_valid(ser_valid), .ser_byte(ser_byte)
    );

    // Small-counter instance that always reads its counter, to see the wrap.
    mmio_bus_decoder #(.CLK_MHZ(3), .TIME_W(8)) dut_wrap (
        .clk(clk), .rst_n(rst_n), .cpu_addr(A_TIME), .cpu_rd_en(1'b1),
        .cpu_wr_en(1'b0), .cpu_size(2'd2), .cpu_wdata(32'd0),
        .cpu_rdata(w_rdata), .mem_addr(w_mem_addr), .mem_size(w_mem_size),
        .mem_wdata(w_mem_wdata), .mem_rd_en(w_mem_rd), .mem_wr_en(w_mem_wr),
        .mem_rdata(32'd0), .switch_in(16'd0), .button_in(16'd0),
        .led_out(w_led), .ser_valid(w_sv), .ser_byte(w_sb)
    );

    // Reference model state.
    int unsigned m_us;
    int          m_pre;
    logic [15:0] m_led;
    logic [15:0] m_sw [2];
    logic [15:0] m_bt [2];
    logic        m_sv;
    logic [7:0]  m_sb;
    int          w_us;
    int          w_pre;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Advance the model at each rising edge using the current inputs.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_us = 0; m_pre = 0; m_led = '0;
            m_sw[0] = '0; m_sw[1] = '0; m_bt[0] = '0; m_bt[1] = '0;
            m_sv = 1'b0; m_sb = '0; w_us = 0; w_pre = 0;
        end else begin
            m_sw[1] = m_sw[0]; m_sw[0] = switch_in;
            m_bt[1] = m_bt[0]; m_bt[0] = button_in;
            m_pre = m_pre + 1;
            if (m_pre == 100) begin m_pre = 0; m_us = m_us + 1; end
            w_pre = w_pre + 1;
            if (w_pre == 3) begin w_pre = 0; w_us = (w_us + 1) % 256; end
            if (cpu_wr_en && cpu_addr == A_LED && cpu_size != 2'd0) m_led = cpu_wdata[15:0];
            m_sv = cpu_wr_en && cpu_addr == A_SER && cpu_size[1];
            if (m_sv) m_sb = cpu_wdata[7:0];
        end
    end

    // Compare every output shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (started && !done) begin
            logic [31:0] exp_rd;
            logic [31:0] mask;
            string tag;
            bit io;
            io = (cpu_addr >= 32'hA000_0000);
            mask = (cpu_size == 2'd0) ? 32'hFF : (cpu_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
            if (!cpu_rd_en) begin
                exp_rd = 0; tag = "R11";
            end else if (!io) begin
                exp_rd = mem_rdata; tag = "R1";
            end else begin
                case (cpu_addr)
                    A_TIME:  begin exp_rd = m_us;         tag = "R3"; end
                    A_LED:   begin exp_rd = 32'(m_led);   tag = "R4"; end
                    A_SW:    begin exp_rd = 32'(m_sw[1]); tag = "R5"; end
                    A_BTN:   begin exp_rd = 32'(m_bt[1]); tag = "R6"; end
                    default: begin exp_rd = 0;            tag = "R9"; end
                endcase
                exp_rd = exp_rd & mask;
                if (cpu_size != 2'd2 && cpu_size != 2'd3) tag = {tag, " R10"};
            end
            check({tag, " cpu_rdata"}, cpu_rdata, exp_rd);
            check(io ? "R2 mem_rd_en" : "R1 mem_rd_en", 32'(mem_rd_en), 32'(cpu_rd_en && !io));
            check(io ? "R2 mem_wr_en" : "R1 mem_wr_en", 32'(mem_wr_en), 32'(cpu_wr_en && !io));
            if (!io) begin
                check("R1 mem_addr", mem_addr, cpu_addr);
                check("R1 mem_wdata", mem_wdata, cpu_wdata);
                check("R1 mem_size", 32'(mem_size), 32'(cpu_size));
            end
            check("R4 led_out", 32'(led_out), 32'(m_led));
            check("R7 ser_valid", 32'(ser_valid), 32'(m_sv));
            check("R7 ser_byte", 32'(ser_byte), 32'(m_sb));
            check("R3 wrap counter", w_rdata, 32'(w_us));
        end
    end

    task automatic acc(input bit rd, input bit wr, input logic [31:0] a,
                       input logic [1:0] sz, input logic [31:0] wd, input int n);
        @(negedge clk);
        cpu_rd_en = rd; cpu_wr_en = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        repeat (n) @(negedge clk);
        cpu_rd_en = 0; cpu_wr_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] led_keep;
        repeat (5) @(negedge clk);
        check("R4 reset led_out", 32'(led_out), 32'd0);
        check("R7 reset ser_valid", 32'(ser_valid), 32'd0);
        rst_n = 1;
        // R1: memory side, including the last address below the window
        acc(1, 0, 32'h0000_0000, 2'd2, 0, 1);
        mem_rdata = 32'h1234_ABCD;
        acc(1, 0, 32'h9FFF_FFFC, 2'd0, 0, 1);
        acc(0, 1, 32'h0000_1000, 2'd1, 32'hCAFE_F00D, 1);
        // R2 R9: window edges read zero and never reach memory
        acc(1, 1, 32'hA000_0000, 2'd2, 32'h5555_5555, 1);
        acc(1, 0, 32'hFFFF_FFFC, 2'd2, 0, 1);
        acc(1, 0, A_SER, 2'd2, 0, 1);
        // R4 R10: light register writes and sized reads
        acc(0, 1, A_LED, 2'd1, 32'h0000_BEEF, 1);
        acc(1, 0, A_LED, 2'd1, 0, 1);
        acc(1, 0, A_LED, 2'd0, 0, 1);
        acc(1, 0, A_LED, 2'd2, 0, 1);
        acc(0, 1, A_LED, 2'd0, 32'h0000_0012, 1);
        check("R4 byte store ignored", 32'(led_out), 32'h0000_BEEF);
        acc(0, 1, A_LED, 2'd3, 32'h1234_5678, 1);
        check("R4 word store low half", 32'(led_out), 32'h0000_5678);
        // R5 R6: re-timed inputs read every cycle across a change
        switch_in = 16'hA5C3;
        acc(1, 0, A_SW, 2'd1, 0, 4);
        button_in = 16'h00F1;
        acc(1, 0, A_BTN, 2'd0, 0, 4);
        button_in = 16'h8002;
        acc(1, 0, A_BTN, 2'd3, 0, 4);
        // R7: back-to-back word stores, then short stores
        acc(0, 1, A_SER, 2'd2, 32'h1111_11A5, 2);
        acc(0, 1, A_SER, 2'd1, 32'h0000_0077, 1);
        acc(0, 1, A_SER, 2'd0, 32'h0000_0066, 1);
        check("R7 short store no strobe", 32'(ser_valid), 32'd0);
        // R8: stores to read-only slots
        led_keep = led_out;
        acc(0, 1, A_TIME, 2'd2, 32'hFFFF_FFFF, 1);
        acc(0, 1, A_SW, 2'd1, 32'h0000_FFFF, 1);
        acc(0, 1, A_BTN, 2'd1, 32'h0000_FFFF, 1);
        check("R8 led after read-only stores", 32'(led_out), 32'(led_keep));
        acc(1, 0, A_SW, 2'd1, 0, 1);
        // R3 R8: counter progress read at all sizes over a long stretch
        acc(1, 0, A_TIME, 2'd2, 0, 300);
        acc(1, 0, A_TIME, 2'd1, 0, 200);
        acc(1, 0, A_TIME, 2'd0, 0, 400);
        // R11: idle port
        acc(0, 0, A_LED, 2'd2, 0, 3);
        @(negedge clk);
        finish_run();
    end

endmodule